// File: doc/BRIEF.md
# AUX Request Header Formatter

This block takes one request for a display auxiliary channel and turns it into the byte stream that a transmit engine sends. A request has a 20-bit target address, a 4-bit request code, a payload length and a payload buffer. The block checks the request code and the length and builds a four-byte header. It then streams the header, followed by the payload on write requests, over a valid/ready byte interface with a marker on the final byte.

When the transmit engine has finished, it returns one status byte and a received byte count. The block turns them into one outcome code, a reply nibble and a transferred length. These appear as a one-cycle completion pulse. A request that fails the checks is answered at once with an error outcome and sends no bytes. From acceptance until the completion, the block reports busy and takes no other request.

Top module: `aux_req_packer`

## Requirements
- R1: Header byte 0 is address bits 7:0 and header byte 1 is address bits 15:8.
- R2: Header byte 2 carries the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R3: Bits 3:0 of header byte 3 are the length minus one, or 0 for a zero length.
- R4: Bits 7:4 of header byte 3 are 3 for a zero length. For any other read they are 4. For any other write they are the low four bits of 4 plus the length, so a 12-byte write gives 0.
- R5: Bit 2 of the request code is ignored when the request is classified. After bit 2 is cleared, codes 0, 2 and 8 are writes, codes 1 and 9 are reads, and every other code completes with outcome 4 (invalid request).
- R6: A length above 16 completes with outcome 5 (too long). This check comes before the code check. A valid write longer than 12 bytes also completes with outcome 5. A rejected request sends no byte, completes on the cycle after it is accepted, and leaves the block idle.
- R7: A read sends only the 4 header bytes. A write sends the header and then the payload bytes, where byte k is taken from payload bits 8k+7:8k. The last-byte marker is high only on the final byte.
- R8: While the transmit side holds ready low, the offered byte and its valid stay unchanged.
- R9: A status byte of 1, 2 or 3 gives outcome 1 (timeout), 2 (flags not zero) or 3 (error) respectively, with reply 0 and length 0. Any other status value gives outcome 0 (success), and the reply is status bits 7:4.
- R10: A successful write reports the request length. A successful read reports the smaller of the received count and the request length.
- R11: Busy is high from the acceptance of a valid request until its completion, and request-ready is its inverse. A request offered while the block is busy has no effect.
- R12: The status is sampled only after the final byte has been sent. Completion is a single-cycle pulse in the cycle after the status is sampled.
- R13: Out of reset the block is idle and ready, and offers no byte and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 20 | Target address |
| req_cmd | input | 4 | Request code |
| req_len | input | LEN_W (5) | Payload length in bytes |
| req_data | input | 8*RD_MAX (128) | Payload buffer, byte k in bits 8k+7:8k |
| tx_valid | output | 1 | Byte offered to the transmit engine |
| tx_ready | input | 1 | Transmit engine takes the byte |
| tx_data | output | 8 | Byte offered |
| tx_last | output | 1 | Offered byte is the final one |
| rsp_valid | input | 1 | Status from the transmit engine is present |
| rsp_status | input | 8 | Status byte |
| rsp_count | input | LEN_W (5) | Bytes received by the engine |
| busy | output | 1 | Transaction outstanding |
| done_valid | output | 1 | Completion pulse |
| done_code | output | 3 | Outcome: 0 success, 1 timeout, 2 flags, 3 error, 4 invalid, 5 too long |
| done_reply | output | 4 | Reply nibble |
| done_len | output | LEN_W (5) | Transferred byte count |

## Verification
The first header byte is on the transmit port in the cycle after acceptance. Each later byte appears in the cycle after the previous one is taken. The bench therefore takes a byte only at the falling edge at which it has itself presented ready. Completion is due one cycle after acceptance for a rejected request, and one cycle after the status cycle for an accepted one. The bench samples the completion at exactly that falling edge, and it treats a completion seen earlier as a miscompare. One falling edge later it checks that the pulse has ended. At that point it also checks that a request offered during the busy window has started no new byte stream.

// File: rtl/aux_req_packer.sv
module aux_req_packer #(
  parameter int RD_MAX = 16,
  parameter int WR_MAX = 12,
  parameter int LEN_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [19:0]           req_addr,
  input  logic [3:0]            req_cmd,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [8*RD_MAX-1:0]   req_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  input  logic                  rsp_valid,
  input  logic [7:0]            rsp_status,
  input  logic [LEN_W-1:0]      rsp_count,
  output logic                  busy,
  output logic                  done_valid,
  output logic [2:0]            done_code,
  output logic [3:0]            done_reply,
  output logic [LEN_W-1:0]      done_len
);

  localparam int HDR   = 4;
  localparam int IDX_W = $clog2(RD_MAX + HDR + 1);
  localparam logic [2:0] OC_OK = 3'd0, OC_TMO = 3'd1, OC_FLG = 3'd2,
                         OC_ERR = 3'd3, OC_INV = 3'd4, OC_BIG = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;

  state_t               st_q;
  logic [19:0]          addr_q;
  logic [3:0]           cmd_q;
  logic [LEN_W-1:0]     len_q;
  logic                 wr_q;
  logic [8*RD_MAX-1:0]  data_q;
  logic [IDX_W-1:0]     idx_q, ntx_q;

  logic [3:0] base;
  logic       is_wr, is_rd, too_long, bad_cmd, wr_long, reject, accept;
  logic [IDX_W-1:0] ntx_d, pidx;
  logic [LEN_W:0]   tot;
  logic [7:0]       hdr3, pay_byte;
  logic [LEN_W-1:0] clamp;

  assign base     = req_cmd & 4'b1011;
  assign is_wr    = (base == 4'h8) || (base == 4'h0) || (base == 4'h2);
  assign is_rd    = (base == 4'h9) || (base == 4'h1);
  assign too_long = req_len > LEN_W'(RD_MAX);
  assign bad_cmd  = !is_wr && !is_rd;
  assign wr_long  = is_wr && (req_len > LEN_W'(WR_MAX));
  assign reject   = too_long || bad_cmd || wr_long;

  assign busy      = (st_q != S_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign ntx_d     = is_wr ? IDX_W'(HDR) + IDX_W'(req_len) : IDX_W'(HDR);

  assign tot  = (LEN_W+1)'(HDR) + (LEN_W+1)'(len_q);
  assign hdr3 = (len_q == '0) ? 8'h30
              : {(wr_q ? tot[3:0] : 4'd4), 4'(len_q - 1'b1)};
  assign pidx     = idx_q - IDX_W'(HDR);
  assign pay_byte = data_q[{pidx, 3'b000} +: 8];

  always_comb begin
    case (idx_q)
      IDX_W'(0): tx_data = addr_q[7:0];
      IDX_W'(1): tx_data = addr_q[15:8];
      IDX_W'(2): tx_data = {cmd_q, addr_q[19:16]};
      IDX_W'(3): tx_data = hdr3;
      default:   tx_data = pay_byte;
    endcase
  end

  assign tx_valid = (st_q == S_SEND);
  assign tx_last  = tx_valid && (idx_q == ntx_q - 1'b1);
  assign clamp    = (rsp_count > len_q) ? len_q : rsp_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      addr_q     <= '0;
      cmd_q      <= '0;
      len_q      <= '0;
      wr_q       <= 1'b0;
      data_q     <= '0;
      idx_q      <= '0;
      ntx_q      <= '0;
      done_valid <= 1'b0;
      done_code  <= OC_OK;
      done_reply <= '0;
      done_len   <= '0;
    end else begin
      done_valid <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          if (reject) begin
            done_valid <= 1'b1;
            done_code  <= too_long ? OC_BIG : (bad_cmd ? OC_INV : OC_BIG);
            done_reply <= '0;
            done_len   <= '0;
          end else begin
            st_q   <= S_SEND;
            addr_q <= req_addr;
            cmd_q  <= req_cmd;
            len_q  <= req_len;
            wr_q   <= is_wr;
            data_q <= req_data;
            idx_q  <= '0;
            ntx_q  <= ntx_d;
          end
        end
        S_SEND: if (tx_ready) begin
          if (tx_last) st_q <= S_WAIT;
          else         idx_q <= idx_q + 1'b1;
        end
        S_WAIT: if (rsp_valid) begin
          st_q       <= S_IDLE;
          done_valid <= 1'b1;
          done_reply <= '0;
          done_len   <= '0;
          case (rsp_status)
            8'd1:    done_code <= OC_TMO;
            8'd2:    done_code <= OC_FLG;
            8'd3:    done_code <= OC_ERR;
            default: begin
              done_code  <= OC_OK;
              done_reply <= rsp_status[7:4];
              done_len   <= wr_q ? len_q : clamp;
            end
          endcase
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R1
  hdr_addr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reject) |=> (tx_valid && tx_data == $past(req_addr[7:0])));

  // R6
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reject) |=> (done_valid && !busy && !tx_valid && done_code >= OC_INV));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R9
  ok_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && rsp_valid && !(rsp_status inside {8'd1, 8'd2, 8'd3}))
    |=> (done_valid && done_code == OC_OK && done_reply == $past(rsp_status[7:4])));

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R12
  no_tx_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (!tx_valid && busy));

endmodule

// File: tb/test_aux_req_packer.sv
module test_aux_req_packer;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [19:0] req_addr = 0;
  logic [3:0] req_cmd = 0;
  logic [4:0] req_len = 0;
  logic [127:0] req_data = 0;
  logic tx_valid, tx_ready = 0, tx_last;
  logic [7:0] tx_data;
  logic rsp_valid = 0;
  logic [7:0] rsp_status = 0;
  logic [4:0] rsp_count = 0;
  logic busy, done_valid;
  logic [2:0] done_code;
  logic [3:0] done_reply;
  logic [4:0] done_len;

  int vec = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aux_req_packer i_aux_req_packer (.*);

  function automatic logic [7:0] pay(input logic [19:0] a, input int k);
    return a[7:0] ^ 8'(k * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] cmd, input logic [4:0] len, input logic [19:0] addr,
                     input logic [7:0] st, input logic [4:0] cnt, input bit stall, input bit stray);
    logic [3:0] b = cmd & 4'b1011;
    bit wr = (b == 0) || (b == 2) || (b == 8);
    bit rd = (b == 1) || (b == 9);
    bit rej;
    int ecode, ereply, elen, nexp, nb = 0;
    bit sent_all = 0, resp = 0, fin = 0;
    logic [7:0] exp_b [0:19];
    logic [3:0] hi;
    if (len > 16) ecode = 5;
    else if (!wr && !rd) ecode = 4;
    else if (wr && len > 12) ecode = 5;
    else ecode = -1;
    rej = (ecode >= 0);
    exp_b[0] = addr[7:0];
    exp_b[1] = addr[15:8];
    exp_b[2] = {cmd, addr[19:16]};
    hi = (len == 0) ? 4'd3 : (wr ? 4'(4 + len) : 4'd4);
    exp_b[3] = {hi, (len == 0) ? 4'd0 : 4'(len - 1)};
    nexp = wr ? 4 + len : 4;
    for (int k = 0; k < 16; k++) if (k + 4 < 20) exp_b[k+4] = pay(addr, k);
    if (!rej) begin
      if (st == 1 || st == 2 || st == 3) begin ecode = st; ereply = 0; elen = 0; end
      else begin ecode = 0; ereply = st[7:4]; elen = wr ? len : ((cnt > len) ? len : cnt); end
    end else begin ereply = 0; elen = 0; end

    @(negedge clk);
    chk(req_ready == 1 && busy == 0, "R11 idle before request", {busy, req_ready}, 2'b01);
    req_valid = 1; req_cmd = cmd; req_len = len; req_addr = addr;
    for (int k = 0; k < 16; k++) req_data[8*k +: 8] = pay(addr, k);
    for (int c = 0; c < 200 && !fin; c++) begin
      @(negedge clk);
      req_valid = 0; rsp_valid = 0;
      if (done_valid) begin
        if (!rej && !resp)
          chk(0, "R12 completion before status", 1, 0);
        else begin
          chk(done_code == 3'(ecode) && done_reply == 4'(ereply) && done_len == 5'(elen),
              rej ? "R6 rejection outcome" : (ecode == 0 ? "R10 success outcome" : "R9 error outcome"),
              {done_code, done_reply, done_len}, {3'(ecode), 4'(ereply), 5'(elen)});
          if (!rej) chk(nb == nexp, "R7 byte count", nb, nexp);
        end
        fin = 1;
      end else if (rej) begin
        chk(0, "R6 rejection not completed next cycle", c, 0);
        fin = 1;
      end else if (!sent_all) begin
        tx_ready = stall ? c[0] : 1'b1;
        if (tx_valid && tx_ready) begin
          chk(tx_data == exp_b[nb], nb < 2 ? "R1 addr byte" : nb == 2 ? "R2 code byte" :
              nb == 3 ? "R3 R4 length byte" : "R7 payload byte", tx_data, exp_b[nb]);
          chk(tx_last == (nb == nexp - 1), "R7 last marker", tx_last, nb == nexp - 1);
          if (tx_last || nb == nexp - 1) sent_all = 1;
          nb++;
        end else if (!tx_valid) begin
          chk(0, "R7 stream gap", nb, 0);
          fin = 1;
        end
      end else if (!resp) begin
        tx_ready = 0;
        chk(!tx_valid && busy && !req_ready, "R12 R11 waiting for status",
            {tx_valid, busy, req_ready}, 3'b010);
        if (stray) begin req_valid = 1; req_cmd = 4'h8; req_len = 0; end
        rsp_valid = 1; rsp_status = st; rsp_count = cnt; resp = 1;
      end
    end
    if (!fin) chk(0, "R12 no completion", 0, 1);
    @(negedge clk);
    req_valid = 0; rsp_valid = 0; tx_ready = 0;
    chk(!done_valid && !busy && !tx_valid, "R12 R11 pulse ends, stray ignored",
        {done_valid, busy, tx_valid}, 3'b000);
  endtask

  initial begin
    logic [7:0] sts [0:6];
    int lens [0:10];
    int n = 0;
    sts = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h20, 8'hA4, 8'hF0};
    lens = '{0, 1, 2, 5, 11, 12, 13, 15, 16, 17, 31};
    repeat (3) @(negedge clk);
    // R13
    chk(!busy && req_ready && !tx_valid && !done_valid, "R13 reset state",
        {busy, req_ready, tx_valid, done_valid}, 4'b0100);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && req_ready && !tx_valid && !done_valid, "R13 after reset release",
        {busy, req_ready, tx_valid, done_valid}, 4'b0100);
    // R5 R6 R7 sweep over all codes and boundary lengths
    for (int c = 0; c < 16; c++)
      for (int l = 0; l < 11; l++) begin
        run(4'(c), 5'(lens[l]), 20'(32'h9_3C5A + c * 32'h1_1111 + l * 77),
            sts[n % 7], 5'((n * 7) % 20), bit'((c ^ l) & 1), lens[l] == 5);
        n++;
      end
    // R9 R10 full status sweep on a read, counts straddling the request length
    for (int s = 0; s < 256; s++)
      run(4'h9 ^ 4'(s[0] << 2), 5'd8, 20'(s * 4099), 8'(s), 5'(s % 17), s[1], 0);
    // R10 writes of every legal length
    for (int l = 0; l <= 12; l++)
      run(4'h0, 5'(l), 20'hF_0000 | 20'(l), 8'h50, 5'd0, l[0], 1);
    if (cyc > 150000) begin bad++; $display("FAIL watchdog"); end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #(5ns * 180000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule